// File: doc/BRIEF.md
# Segment LCD Frame Timing Generator

This block turns a slow timing clock into the sequencing for a time-multiplexed segment display. A counter chain divides the clock into phases. Each phase is `(16 + DIV) * 2^PS` input cycles long, and is made of `16 + DIV` steps of `2^PS` cycles. The block walks through a run of common-electrode (COM) phases, from one to eight as the duty code selects. It can then append a number of idle dead-time phases before the next frame starts.

In every COM phase it drives a drive-enable signal for the first `PON` steps, or for the whole phase when the high-drive bit is set. In dead-time phases every drive output is held low. The frame-control fields are sampled when the block is enabled and again at each frame boundary. A sync flag shows whether the settings on the inputs are the ones now in use.

Top module: `lcd_frame_timer`

## Requirements
- R1: Each phase is exactly `(16 + div_i) * 2^ps_i` clock cycles long. `phase_stb_o` is high for one cycle on the first cycle of every COM phase.
- R2: `duty_i` selects the number N of COM phases per frame: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 3, 3'b011 gives 4, and 3'b100 or any higher code gives 8. `com_idx_o` counts 0, 1, ... N-1 in order, one value per COM phase.
- R3: `frame_stb_o` is high for one cycle on the first cycle of COM phase 0. A frame lasts N + `dead_i` phases.
- R4: When `hd_i` is 0, `drive_o` is high during the first `pon_i * 2^ps_i` cycles of each COM phase. The length is clipped to half of the phase, and `pon_i` = 0 gives no pulse.
- R5: When `hd_i` is 1, `drive_o` is high for the whole of every COM phase, whatever the value of `pon_i`.
- R6: After the last COM phase, `dead_i` dead phases follow. During them `dead_o` is 1, `drive_o` and `phase_stb_o` are 0, and `com_idx_o` holds N-1. A value of 0 inserts no dead phase.
- R7: While `en_i` is 0, from the next cycle on, `com_idx_o` is 0 and `phase_stb_o`, `frame_stb_o`, `drive_o` and `dead_o` are 0. The first cycle after `en_i` returns to 1 is the start of a frame.
- R8: The fields `ps_i`, `div_i`, `duty_i`, `pon_i`, `hd_i` and `dead_i` are applied only when the block is enabled or at a frame boundary. A change in the middle of a frame does not alter the rest of that frame.
- R9: `sync_o` is 1 exactly when the applied settings equal the inputs. It drops in the same cycle a field changes. It returns on the first cycle of the next frame while running, or one cycle later while disabled.
- R10: During reset all strobes, `drive_o` and `dead_o` are 0 and `com_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| ps_i | input | 4 | Prescale exponent: a step lasts 2^ps_i cycles |
| div_i | input | 4 | Divider: a phase lasts 16 + div_i steps |
| duty_i | input | 3 | COM phase count code |
| pon_i | input | 3 | Drive pulse length in steps |
| hd_i | input | 1 | Permanent high drive |
| dead_i | input | 3 | Dead phases per frame |
| phase_stb_o | output | 1 | First cycle of a COM phase |
| frame_stb_o | output | 1 | First cycle of a frame |
| com_idx_o | output | 3 | Current COM phase index |
| drive_o | output | 1 | Drive enable |
| dead_o | output | 1 | Dead phase in progress |
| sync_o | output | 1 | Applied settings match the inputs |

## Verification
The bench exercises several key corner cases:
- The eight-phase duty, together with an undefined duty code that must fall back to eight phases. A wrong decode would produce too few index steps and early frame strobes.
- A pulse length of zero, and high drive combined with a zero pulse length. These show whether the gating drops the pulse correctly or wrongly lets the pulse length override high drive.
- The largest dead-time count. A dead counter that is off by one would shift every later frame strobe.
- A change of the pulse length in the middle of a frame, which must leave the current frame untouched and hold the sync flag low until the frame boundary.
- Disabling the block in the middle of a phase, which must park the index at 0 and restart cleanly with a frame strobe.

// File: rtl/lcd_timer_pkg.sv
package lcd_timer_pkg;
  localparam int PS_W     = 4;
  localparam int DIV_W    = 4;
  localparam int DUTY_W   = 3;
  localparam int PON_W    = 3;
  localparam int DEAD_W   = 3;
  localparam int COM_W    = 3;
  localparam int DIV_BASE = 16;
  localparam int UC_W     = (1 << PS_W) - 1;
  localparam int SC_W     = $clog2(DIV_BASE + (1 << DIV_W));

  typedef struct packed {
    logic [PS_W-1:0]   ps;
    logic [DIV_W-1:0]  div;
    logic [DUTY_W-1:0] duty;
    logic [PON_W-1:0]  pon;
    logic              hd;
    logic [DEAD_W-1:0] dead;
  } cfg_t;

  function automatic logic [COM_W:0] phase_count(input logic [DUTY_W-1:0] d);
    case (d)
      3'd0:    phase_count = (COM_W+1)'(1);
      3'd1:    phase_count = (COM_W+1)'(2);
      3'd2:    phase_count = (COM_W+1)'(3);
      3'd3:    phase_count = (COM_W+1)'(4);
      default: phase_count = (COM_W+1)'(8);
    endcase
  endfunction
endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_timer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic sync_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o  = cfg_q;
  assign sync_o = (cfg_q == cfg_i);
endmodule

// File: rtl/lcd_prescaler.sv
module lcd_prescaler
  import lcd_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [SC_W-1:0]  step_o,
  output logic             phase_start_o,
  output logic             phase_end_o
);
  logic [UC_W-1:0] uc_q;
  logic [SC_W-1:0] sc_q;
  logic [UC_W:0]   unit_span;
  logic [UC_W:0]   unit_span_m1;
  logic [UC_W-1:0] unit_last;
  logic [SC_W-1:0] step_last;
  logic            unit_end;

  always_comb begin
    unit_span    = (UC_W+1)'(1) << ps_i;
    unit_span_m1 = unit_span - 1'b1;
    unit_last    = unit_span_m1[UC_W-1:0];
    step_last    = SC_W'(DIV_BASE) + SC_W'(div_i) - 1'b1;
  end

  assign unit_end      = (uc_q == unit_last);
  assign phase_end_o   = run_i && unit_end && (sc_q == step_last);
  assign phase_start_o = run_i && (uc_q == '0) && (sc_q == '0);
  assign step_o        = sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uc_q <= '0;
      sc_q <= '0;
    end else if (clr_i) begin
      uc_q <= '0;
      sc_q <= '0;
    end else if (run_i) begin
      uc_q <= unit_end ? '0 : uc_q + 1'b1;
      if (unit_end) sc_q <= (sc_q == step_last) ? '0 : sc_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              phase_end_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic [COM_W-1:0]  com_idx_o,
  output logic              in_dead_o,
  output logic              frame_end_o
);
  logic [COM_W-1:0]  com_q;
  logic [DEAD_W-1:0] dc_q;
  logic              dead_q;
  logic [COM_W:0]    n_phases;
  logic [COM_W:0]    n_m1;
  logic [COM_W-1:0]  last_com;
  logic [DEAD_W-1:0] last_dead;
  logic              com_done;
  logic              dead_done;

  always_comb begin
    n_phases  = phase_count(duty_i);
    n_m1      = n_phases - 1'b1;
    last_com  = n_m1[COM_W-1:0];
    last_dead = dead_i - 1'b1;
  end

  assign com_done    = !dead_q && (com_q == last_com);
  assign dead_done   = dead_q && (dc_q == last_dead);
  assign frame_end_o = phase_end_i && ((com_done && (dead_i == '0)) || dead_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_q  <= '0;
      dc_q   <= '0;
      dead_q <= 1'b0;
    end else if (clr_i) begin
      com_q  <= '0;
      dc_q   <= '0;
      dead_q <= 1'b0;
    end else if (phase_end_i) begin
      if (dead_q) begin
        if (dead_done) begin
          dead_q <= 1'b0;
          com_q  <= '0;
          dc_q   <= '0;
        end else begin
          dc_q <= dc_q + 1'b1;
        end
      end else if (com_done) begin
        if (dead_i == '0) com_q <= '0;
        else begin
          dead_q <= 1'b1;
          dc_q   <= '0;
        end
      end else begin
        com_q <= com_q + 1'b1;
      end
    end
  end

  assign com_idx_o = com_q;
  assign in_dead_o = dead_q;
endmodule

// File: rtl/lcd_drive_pulse.sv
module lcd_drive_pulse
  import lcd_timer_pkg::*;
(
  input  logic             run_i,
  input  logic             in_dead_i,
  input  logic [SC_W-1:0]  step_i,
  input  logic [PON_W-1:0] pon_i,
  input  logic             hd_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             drive_o
);
  logic [SC_W-1:0] half_steps;
  logic [SC_W-1:0] pon_ext;
  logic [SC_W-1:0] pon_eff;

  always_comb begin
    half_steps = (SC_W'(DIV_BASE) + SC_W'(div_i)) >> 1;
    pon_ext    = SC_W'(pon_i);
    pon_eff    = (pon_ext < half_steps) ? pon_ext : half_steps;
    drive_o    = run_i && !in_dead_i && (hd_i || (step_i < pon_eff));
  end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [PON_W-1:0]  pon_i,
  input  logic              hd_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              phase_stb_o,
  output logic              frame_stb_o,
  output logic [COM_W-1:0]  com_idx_o,
  output logic              drive_o,
  output logic              dead_o,
  output logic              sync_o
);
  cfg_t            cfg_live;
  cfg_t            cfg_q;
  logic            run_q;
  logic            clr;
  logic            load;
  logic            frame_end;
  logic            phase_start;
  logic            phase_end;
  logic            in_dead;
  logic [SC_W-1:0] step;
  logic [COM_W-1:0] com_idx;

  assign cfg_live = '{ps: ps_i, div: div_i, duty: duty_i, pon: pon_i, hd: hd_i, dead: dead_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign clr  = !en_i;
  // settings are captured while idle and once per frame boundary
  assign load = !run_q || frame_end;

  lcd_cfg_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_live),
    .cfg_o  (cfg_q),
    .sync_o (sync_o)
  );

  lcd_prescaler u_presc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr),
    .run_i         (run_q),
    .ps_i          (cfg_q.ps),
    .div_i         (cfg_q.div),
    .step_o        (step),
    .phase_start_o (phase_start),
    .phase_end_o   (phase_end)
  );

  lcd_phase_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .phase_end_i (phase_end),
    .duty_i      (cfg_q.duty),
    .dead_i      (cfg_q.dead),
    .com_idx_o   (com_idx),
    .in_dead_o   (in_dead),
    .frame_end_o (frame_end)
  );

  lcd_drive_pulse u_drive (
    .run_i     (run_q),
    .in_dead_i (in_dead),
    .step_i    (step),
    .pon_i     (cfg_q.pon),
    .hd_i      (cfg_q.hd),
    .div_i     (cfg_q.div),
    .drive_o   (drive_o)
  );

  assign phase_stb_o = phase_start && !in_dead;
  assign frame_stb_o = phase_stb_o && (com_idx == '0);
  assign dead_o      = run_q && in_dead;
  assign com_idx_o   = com_idx;
endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk
  import lcd_timer_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             phase_stb_o,
  input logic             frame_stb_o,
  input logic [COM_W-1:0] com_idx_o,
  input logic             drive_o,
  input logic             dead_o,
  input logic             run_i,
  input cfg_t             cfg_i
);
  localparam int CNT_W = SC_W + UC_W;

  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] hi_limit;

  assign hi_limit = CNT_W'((SC_W'(DIV_BASE) + SC_W'(cfg_i.div)) >> 1) << cfg_i.ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_cnt <= '0;
    else if (drive_o && !cfg_i.hd) hi_cnt <= hi_cnt + 1'b1;
    else                          hi_cnt <= '0;
  end

  assert_drive_clip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o && !cfg_i.hd |-> hi_cnt < hi_limit);

  assert_com_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_stb_o && !frame_stb_o |-> com_idx_o == COM_W'($past(com_idx_o) + 1'b1));

  assert_dead_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !drive_o && !phase_stb_o);

  assert_dead_then_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> !phase_stb_o || frame_stb_o);

  assert_disable_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> com_idx_o == '0 && !phase_stb_o && !frame_stb_o && !drive_o && !dead_o);

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !frame_stb_o |-> $stable(cfg_i));
endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .phase_stb_o (phase_stb_o),
  .frame_stb_o (frame_stb_o),
  .com_idx_o   (com_idx_o),
  .drive_o     (drive_o),
  .dead_o      (dead_o),
  .run_i       (run_q),
  .cfg_i       (cfg_q)
);

// File: tb/sim_lcd_frame_timer.sv
module sim_lcd_frame_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {ps, div, duty, pon, hd, dead}
  localparam logic [17:0] VECS [NVEC] = '{
    {4'd0, 4'd0,  3'd0, 3'd3, 1'b0, 3'd0},
    {4'd1, 4'd2,  3'd3, 3'd5, 1'b0, 3'd0},
    {4'd0, 4'd15, 3'd4, 3'd7, 1'b0, 3'd2},
    {4'd2, 4'd1,  3'd2, 3'd0, 1'b1, 3'd1},
    {4'd0, 4'd3,  3'd1, 3'd0, 1'b0, 3'd7},
    {4'd3, 4'd0,  3'd1, 3'd1, 1'b0, 3'd0},
    {4'd0, 4'd0,  3'd7, 3'd1, 1'b0, 3'd0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] ps_i = '0;
  logic [3:0] div_i = '0;
  logic [2:0] duty_i = '0;
  logic [2:0] pon_i = '0;
  logic       hd_i = 1'b0;
  logic [2:0] dead_i = '0;
  logic       phase_stb_o, frame_stb_o, drive_o, dead_o, sync_o;
  logic [2:0] com_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lcd_frame_timer u0 (
    .clk_i, .rst_ni, .en_i, .ps_i, .div_i, .duty_i, .pon_i, .hd_i, .dead_i,
    .phase_stb_o, .frame_stb_o, .com_idx_o, .drive_o, .dead_o, .sync_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic int n_of(input logic [2:0] d);
    case (d)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      default: return 8;
    endcase
  endfunction

  // expected {phase_stb, frame_stb, com[2:0], drive, dead} at frame offset k
  function automatic logic [6:0] model(input int k, input int ps, input int dv, input int n,
                                       input int pon, input bit hd, input int dd);
    int u, p, fl, kk, ph, off, st, half, pe;
    bit in_d;
    u = 1 << ps;
    p = (16 + dv) * u;
    fl = (n + dd) * p;
    kk = k % fl;
    ph = kk / p;
    off = kk % p;
    st = off / u;
    in_d = (ph >= n);
    half = (16 + dv) / 2;
    pe = (pon < half) ? pon : half;
    model = {(!in_d && off == 0), (kk == 0), 3'(in_d ? n - 1 : ph),
             (!in_d && (hd || st < pe)), in_d};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R10 reset state
    chk(!phase_stb_o && !frame_stb_o && !drive_o && !dead_o && com_idx_o == 0,
        "R10 outputs idle in reset", {phase_stb_o, frame_stb_o, drive_o, dead_o, com_idx_o}, 0);
    rst_ni = 1'b1;
    step();

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      int n, fl, first_k;
      logic [6:0] exp_v, act_v, first_a, first_e;
      bit bad;
      en_i = 1'b0;
      {ps_i, div_i, duty_i, pon_i, hd_i, dead_i} = VECS[v];
      step();
      step();
      n = n_of(duty_i);
      fl = (n + int'(dead_i)) * ((16 + int'(div_i)) << ps_i);
      en_i = 1'b1;
      bad = 1'b0;
      first_k = 0;
      first_a = '0;
      first_e = '0;
      for (int k = 0; k < 2 * fl; k++) begin
        step();
        exp_v = model(k, ps_i, div_i, n, pon_i, hd_i, dead_i);
        act_v = {phase_stb_o, frame_stb_o, com_idx_o, drive_o, dead_o};
        if (act_v !== exp_v && !bad) begin
          bad = 1'b1;
          first_k = k;
          first_a = act_v;
          first_e = exp_v;
        end
      end
      if (bad) $display("vector %0d first mismatch at cycle %0d", v, first_k);
      chk(!bad, "R1 R2 R3 R4 R5 R6 timing vector", first_a, first_e);
    end

    // R8 R9: mid-frame change of pulse length
    en_i = 1'b0;
    {ps_i, div_i, duty_i, pon_i, hd_i, dead_i} = {4'd0, 4'd0, 3'd1, 3'd2, 1'b0, 3'd1};
    step();
    step();
    chk(sync_o == 1'b1, "R9 sync while idle", sync_o, 1);
    en_i = 1'b1;
    for (int k = 0; k < 52; k++) begin
      step();
      if (k == 5) begin
        pon_i = 3'd6;
        #1;
        chk(sync_o == 1'b0, "R9 sync drops on change", sync_o, 0);
      end
      if (k == 19) chk(drive_o == 1'b0, "R8 old pulse length kept", drive_o, 0);
      if (k == 47) chk(sync_o == 1'b0, "R9 sync low until boundary", sync_o, 0);
      if (k == 48) begin
        chk(frame_stb_o == 1'b1, "R3 frame strobe after dead", frame_stb_o, 1);
        chk(sync_o == 1'b1, "R9 sync back at frame start", sync_o, 1);
      end
      if (k == 51) chk(drive_o == 1'b1, "R8 new pulse length applied", drive_o, 1);
    end

    // R7: disable mid-phase then restart
    for (int k = 52; k < 66; k++) step();
    chk(com_idx_o == 3'd1 && drive_o == 1'b1, "R7 running before disable",
        {com_idx_o, drive_o}, {3'd1, 1'b1});
    en_i = 1'b0;
    step();
    chk(com_idx_o == 3'd0 && !drive_o && !phase_stb_o && !frame_stb_o && !dead_o,
        "R7 idle after disable", {com_idx_o, drive_o, phase_stb_o, frame_stb_o, dead_o}, 0);
    en_i = 1'b1;
    step();
    chk(frame_stb_o && phase_stb_o && com_idx_o == 0 && drive_o,
        "R7 restart at frame start", {frame_stb_o, phase_stb_o, com_idx_o, drive_o}, 6'b110001);

    // R9: change while disabled
    en_i = 1'b0;
    step();
    dead_i = 3'd4;
    #1;
    chk(sync_o == 1'b0, "R9 idle change seen", sync_o, 0);
    step();
    chk(sync_o == 1'b1, "R9 idle resync next cycle", sync_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule